// File: doc/BRIEF.md
# Linked-List Command Packet Walker

This block follows a chain of command packets held in main memory and hands the payload of each packet, one 32-bit word at a time, to a downstream graphics command consumer. Each packet begins with one header word. The top byte of the header is the number of payload words that follow it. The low 24 bits hold the address of the next packet. The walk finishes when the current address has its bit 23 set.

A single-cycle `start` strobe launches a walk from `start_addr`. The block then issues word reads on a simple request/response memory port, one read at a time. It presents payload words on a valid/ready stream. It also keeps an estimated cost for the walk: five units for every packet visited plus one unit for each payload word. A node counter stops a chain that loops back on itself. When the walk ends, the block raises `done` for one cycle and holds the final link address, the cost and an abort flag until the next walk begins.

Top module: `ll_dma_walker`

## Requirements
- R1: A header word is decoded with bits 31:24 as the payload word count and bits 23:0 as the link to the next packet.
- R2: The start address is reduced to its low 24 bits. A current address with bit 23 set ends the walk without any memory read for it, so a start address with bit 23 set completes with no reads, zero cost and no payload.
- R3: Every memory read uses the current address masked to its low 21 bits with bits 1:0 cleared. Payload words are read from the consecutive word addresses that follow the header.
- R4: Exactly the header's count of payload words is forwarded, in memory order.
- R5: A packet with a zero count forwards nothing, and the walk moves on to its link.
- R6: The reported cost is the sum of (5 + count) over all visited packets. It is cleared when a walk starts.
- R7: After NODE_LIMIT (default 8192) packet headers have been read, the next address, if it is not a terminator, ends the walk with `loop_abort` = 1.
- R8: While `pl_valid` is high and `pl_ready` is low, `pl_data` holds its value and no memory read is issued.
- R9: `done` is a one-cycle pulse. At that pulse `progress_addr` shows the 24-bit address that ended the walk: the terminator, or, on abort, the address that would have been visited next.
- R10: A `start` strobe that arrives while a walk is in progress is ignored.
- R11: After reset, `mem_req`, `pl_valid`, `done` and `loop_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| start_addr | input | 32 | Address of the first packet |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 21 | Byte address of the read, word aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pl_valid | output | 1 | Payload word valid |
| pl_data | output | 32 | Payload word |
| pl_ready | input | 1 | Consumer ready |
| done | output | 1 | Walk finished, one-cycle pulse |
| loop_abort | output | 1 | Last walk stopped at the node limit |
| progress_addr | output | 24 | Final link address of the last walk |
| cost | output | 32 | Estimated cost of the last walk |

## Verification
The bench runs a chain that mixes a zero-count packet with counted ones. It checks that the payload comes out in order and that the cost adds up. If the design mishandled a zero count, it would emit a stray word or stall. A start address with garbage in its top byte and a link with bit 22 set test both masks: a design that masked wrongly would read the wrong memory word. A start address that is already a terminator must finish with no reads at all. A packet that links to itself must abort after exactly the limit: an off-by-one would show up in the cost. Heavy backpressure and a second start strobe in the middle of a walk must leave the stream and the result unchanged.

// File: rtl/lldw_pkg.sv
package lldw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_HDR_REQ,
      ST_HDR_WAIT,
      ST_PL_REQ,
      ST_PL_WAIT,
      ST_PL_OUT
   } walk_st_t;
endpackage

// File: rtl/lldw_hdr_split.sv
module lldw_hdr_split #(
   parameter int DATA_W         = 32,
   parameter int LEN_W          = 8,
   parameter int LINK_W         = 24,
   parameter int COST_W         = 32,
   parameter int NODE_BASE_COST = 5
) (
   input  logic [DATA_W-1:0] hdr_word,
   output logic [LEN_W-1:0]  len,
   output logic [LINK_W-1:0] link,
   output logic [COST_W-1:0] node_cost
);
   generate
      if (LEN_W + LINK_W != DATA_W) begin : g_bad_split
         $error("header fields must fill the data word exactly");
      end
      if (COST_W <= LEN_W) begin : g_bad_cost
         $error("cost width must exceed length width");
      end
   endgenerate

   // count in the top byte, link in the low bits (R1)
   assign len       = hdr_word[DATA_W-1 -: LEN_W];
   assign link      = hdr_word[LINK_W-1:0];
   assign node_cost = COST_W'(NODE_BASE_COST) + COST_W'(len);
endmodule

// File: rtl/lldw_walk_ctr.sv
module lldw_walk_ctr #(
   parameter int COST_W     = 32,
   parameter int NODE_LIMIT = 8192,
   parameter bit COST_SAT   = 1'b1,
   localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [COST_W-1:0] add,
   output logic [CNT_W-1:0]  nodes,
   output logic              at_limit,
   output logic [COST_W-1:0] cost
);
   generate
      if (NODE_LIMIT < 1) begin : g_bad_limit
         $error("node limit must be at least one");
      end
   endgenerate

   logic [COST_W-1:0] cost_next;

   generate
      if (COST_SAT) begin : g_sat
         logic [COST_W:0] wide;
         assign wide      = {1'b0, cost} + {1'b0, add};
         assign cost_next = wide[COST_W] ? {COST_W{1'b1}} : wide[COST_W-1:0];
      end else begin : g_wrap
         assign cost_next = cost + add;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nodes <= '0;
         cost  <= '0;
      end else if (clear) begin
         nodes <= '0;
         cost  <= '0;
      end else if (take) begin
         nodes <= nodes + CNT_W'(1);
         cost  <= cost_next;
      end
   end

   assign at_limit = (nodes == CNT_W'(NODE_LIMIT));

   // a header is never taken once the limit has been reached (R7)
   assert_take_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (nodes < CNT_W'(NODE_LIMIT)));

   // the counter never passes the limit (R7)
   assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nodes <= CNT_W'(NODE_LIMIT));
endmodule

// File: rtl/lldw_out_stage.sv
module lldw_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] dout,
   output logic              fire
);
   assign fire = valid & ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (fire) begin
         valid <= 1'b0;
      end
   end

   // a held word is neither dropped nor changed (R8)
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(dout)));

   // the controller only loads into an empty stage (R8)
   assert_load_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !valid);
endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker
   import lldw_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int LEN_W          = 8,
   parameter int LINK_W         = 24,
   parameter int MEM_AW         = 21,
   parameter int COST_W         = 32,
   parameter int NODE_LIMIT     = 8192,
   parameter int NODE_BASE_COST = 5,
   parameter bit COST_SAT       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       start_addr,
   output logic              mem_req,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              pl_valid,
   output logic [DATA_W-1:0] pl_data,
   input  logic              pl_ready,
   output logic              done,
   output logic              loop_abort,
   output logic [LINK_W-1:0] progress_addr,
   output logic [COST_W-1:0] cost
);
   localparam int TERM_BIT = LINK_W - 1;
   localparam int CNT_W    = $clog2(NODE_LIMIT + 1);
   localparam int WORD_B   = DATA_W / 8;

   generate
      if (MEM_AW >= LINK_W || MEM_AW < 3) begin : g_bad_aw
         $error("memory address width must lie below the link width");
      end
      if (LINK_W > 32) begin : g_bad_link
         $error("link width cannot exceed the start address width");
      end
      if (DATA_W != 32) begin : g_bad_word
         $error("the packet format assumes 32-bit words");
      end
   endgenerate

   walk_st_t          st;
   logic [LINK_W-1:0] cur_q, nxt_q;
   logic [MEM_AW-1:0] ptr_q;
   logic [LEN_W-1:0]  rem_q;
   logic              done_q, abort_q;
   logic [LINK_W-1:0] prog_q;

   logic [LEN_W-1:0]  hdr_len;
   logic [LINK_W-1:0] hdr_link;
   logic [COST_W-1:0] hdr_cost;
   logic [CNT_W-1:0]  node_cnt;
   logic              at_limit;
   logic              ctr_clear, ctr_take;
   logic              out_load, out_fire;

   lldw_hdr_split #(
      .DATA_W(DATA_W), .LEN_W(LEN_W), .LINK_W(LINK_W),
      .COST_W(COST_W), .NODE_BASE_COST(NODE_BASE_COST)
   ) u_split (
      .hdr_word (mem_rdata),
      .len      (hdr_len),
      .link     (hdr_link),
      .node_cost(hdr_cost)
   );

   assign ctr_clear = (st == ST_IDLE) && start;
   assign ctr_take  = (st == ST_HDR_WAIT) && mem_rvalid;

   lldw_walk_ctr #(
      .COST_W(COST_W), .NODE_LIMIT(NODE_LIMIT), .COST_SAT(COST_SAT)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ctr_clear),
      .take    (ctr_take),
      .add     (hdr_cost),
      .nodes   (node_cnt),
      .at_limit(at_limit),
      .cost    (cost)
   );

   assign out_load = (st == ST_PL_WAIT) && mem_rvalid;

   lldw_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .load (out_load),
      .din  (mem_rdata),
      .ready(pl_ready),
      .valid(pl_valid),
      .dout (pl_data),
      .fire (out_fire)
   );

   assign mem_req  = (st == ST_HDR_REQ) || (st == ST_PL_REQ);
   assign mem_addr = {ptr_q[MEM_AW-1:2], 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_q   <= '0;
         nxt_q   <= '0;
         ptr_q   <= '0;
         rem_q   <= '0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         prog_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  cur_q   <= start_addr[LINK_W-1:0];
                  abort_q <= 1'b0;
                  st      <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (cur_q[TERM_BIT]) begin
                  done_q <= 1'b1;
                  prog_q <= cur_q;
                  st     <= ST_IDLE;
               end else if (at_limit) begin
                  done_q  <= 1'b1;
                  abort_q <= 1'b1;
                  prog_q  <= cur_q;
                  st      <= ST_IDLE;
               end else begin
                  ptr_q <= cur_q[MEM_AW-1:0];
                  st    <= ST_HDR_REQ;
               end
            end
            ST_HDR_REQ: st <= ST_HDR_WAIT;
            ST_HDR_WAIT: begin
               if (mem_rvalid) begin
                  rem_q <= hdr_len;
                  nxt_q <= hdr_link;
                  ptr_q <= ptr_q + MEM_AW'(WORD_B);
                  if (hdr_len == '0) begin
                     cur_q <= hdr_link;
                     st    <= ST_CHECK;
                  end else begin
                     st <= ST_PL_REQ;
                  end
               end
            end
            ST_PL_REQ: st <= ST_PL_WAIT;
            ST_PL_WAIT: begin
               if (mem_rvalid) st <= ST_PL_OUT;
            end
            ST_PL_OUT: begin
               if (out_fire) begin
                  ptr_q <= ptr_q + MEM_AW'(WORD_B);
                  rem_q <= rem_q - LEN_W'(1);
                  if (rem_q == LEN_W'(1)) begin
                     cur_q <= nxt_q;
                     st    <= ST_CHECK;
                  end else begin
                     st <= ST_PL_REQ;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done          = done_q;
   assign loop_abort    = abort_q;
   assign progress_addr = prog_q;

   // no fetch while the consumer is stalling the stream (R8)
   assert_no_fetch_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_valid && !pl_ready) |-> !mem_req);

   // completion is a single-cycle pulse (R9)
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // a normal finish always reports a terminator address (R2)
   assert_term_reported_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !loop_abort) |-> progress_addr[TERM_BIT]);

   // the abort flag only appears together with completion (R7)
   assert_abort_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_abort) |-> done);

   // a payload word is only loaded after the read that fetched it (R3)
   assert_resp_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pl_valid) |-> $past(mem_rvalid));
endmodule

// File: tb/tb_ll_dma_walker.sv
module tb_ll_dma_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic        mem_req;
   logic [20:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        pl_valid;
   logic [31:0] pl_data;
   logic        pl_ready = 1'b1;
   logic        done;
   logic        loop_abort;
   logic [23:0] progress_addr;
   logic [31:0] cost;

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [0:4095];
   logic [31:0] got [0:255];
   logic [20:0] req_log [0:255];
   int ngot = 0;
   int nreq = 0;
   int ndone = 0;
   int cyc = 0;
   bit bp_mode = 1'b0;

   logic        r_abort;
   logic [23:0] r_prog;
   logic [31:0] r_cost;

   always #2 clk = ~clk;

   ll_dma_walker dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .pl_valid(pl_valid), .pl_data(pl_data),
      .pl_ready(pl_ready), .done(done), .loop_abort(loop_abort),
      .progress_addr(progress_addr), .cost(cost)
   );

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem[mem_addr[13:2]];
      if (mem_req) begin
         req_log[nreq % 256] <= mem_addr;
         nreq <= nreq + 1;
      end
      if (pl_valid && pl_ready) begin
         got[ngot % 256] <= pl_data;
         ngot <= ngot + 1;
      end
      if (done) ndone <= ndone + 1;
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      pl_ready <= bp_mode ? (cyc % 3 == 0) : 1'b1;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
   endtask

   task automatic launch(input logic [31:0] a);
      @(negedge clk);
      start_addr = a;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 60000) begin
         @(negedge clk);
         n++;
      end
      check(done === 1'b1, "R9 done within bound (watchdog)", {31'b0, done}, 32'h1);
      r_abort = loop_abort;
      r_prog  = progress_addr;
      r_cost  = cost;
      @(negedge clk);
      check(done === 1'b0, "R9 done is one cycle", {31'b0, done}, 32'h0);
   endtask

   task automatic build_chain();
      clear_mem();
      mem[64]  = {8'd2, 24'h000200};
      mem[65]  = 32'hA000_0001;
      mem[66]  = 32'hA000_0002;
      mem[128] = {8'd0, 24'h000300};
      mem[192] = {8'd3, 24'hFFFFFF};
      mem[193] = 32'hA000_0003;
      mem[194] = 32'hA000_0004;
      mem[195] = 32'hA000_0005;
   endtask

   task automatic check_chain(input int base, input string tag);
      check(ngot - base == 5, {tag, " R4 R5 payload count"}, ngot - base, 5);
      for (int i = 0; i < 5; i++)
         check(got[(base + i) % 256] == 32'hA000_0001 + i, {tag, " R4 payload order"},
               got[(base + i) % 256], 32'hA000_0001 + i);
      check(r_cost == 32'd20, {tag, " R6 cost"}, r_cost, 32'd20);
      check(r_prog == 24'hFFFFFF, {tag, " R9 R1 progress"}, {8'h0, r_prog}, 32'h00FFFFFF);
      check(r_abort == 1'b0, {tag, " R7 no abort"}, {31'b0, r_abort}, 32'h0);
   endtask

   task automatic t_reset();
      check(mem_req == 1'b0, "R11 mem_req at reset", {31'b0, mem_req}, 32'h0);
      check(pl_valid == 1'b0, "R11 pl_valid at reset", {31'b0, pl_valid}, 32'h0);
      check(done == 1'b0, "R11 done at reset", {31'b0, done}, 32'h0);
      check(loop_abort == 1'b0, "R11 loop_abort at reset", {31'b0, loop_abort}, 32'h0);
   endtask

   task automatic t_chain();
      int base;
      build_chain();
      bp_mode = 1'b0;
      base = ngot;
      launch(32'h0000_0100);
      wait_done();
      check_chain(base, "chain");
   endtask

   task automatic t_backpressure();
      int base;
      build_chain();
      bp_mode = 1'b1;
      base = ngot;
      launch(32'h0000_0100);
      wait_done();
      bp_mode = 1'b0;
      check_chain(base, "backpressure R8");
   endtask

   task automatic t_term_start();
      int rb, pb;
      rb = nreq;
      pb = ngot;
      launch(32'h0080_0010);
      wait_done();
      check(nreq - rb == 0, "R2 no reads for terminator start", nreq - rb, 0);
      check(ngot - pb == 0, "R2 no payload", ngot - pb, 0);
      check(r_cost == 0, "R2 R6 zero cost", r_cost, 0);
      check(r_prog == 24'h800010, "R2 progress", {8'h0, r_prog}, 32'h00800010);
   endtask

   task automatic t_mask();
      int rb, pb;
      clear_mem();
      mem[64] = {8'd1, 24'h400040};
      mem[65] = 32'hB000_0001;
      mem[16] = {8'd0, 24'h800000};
      rb = nreq;
      pb = ngot;
      launch(32'hFF20_0100);
      wait_done();
      check(nreq - rb == 3, "R3 read count", nreq - rb, 3);
      check(req_log[rb % 256] == 21'h000100, "R3 R2 masked header addr",
            {11'b0, req_log[rb % 256]}, 32'h100);
      check(req_log[(rb + 1) % 256] == 21'h000104, "R3 payload addr",
            {11'b0, req_log[(rb + 1) % 256]}, 32'h104);
      check(req_log[(rb + 2) % 256] == 21'h000040, "R3 link masked to 21 bits",
            {11'b0, req_log[(rb + 2) % 256]}, 32'h40);
      check(ngot - pb == 1 && got[pb % 256] == 32'hB000_0001, "R4 single word",
            got[pb % 256], 32'hB000_0001);
      check(r_cost == 32'd11, "R6 cost", r_cost, 32'd11);
      check(r_prog == 24'h800000, "R9 progress", {8'h0, r_prog}, 32'h00800000);
   endtask

   task automatic t_loop();
      int pb;
      clear_mem();
      mem[16] = {8'd0, 24'h000040};
      pb = ngot;
      launch(32'h0000_0040);
      wait_done();
      check(r_abort == 1'b1, "R7 abort flag", {31'b0, r_abort}, 32'h1);
      check(r_cost == 32'd40960, "R7 R6 cost at limit", r_cost, 32'd40960);
      check(r_prog == 24'h000040, "R7 progress", {8'h0, r_prog}, 32'h40);
      check(ngot - pb == 0, "R5 no payload", ngot - pb, 0);
   endtask

   task automatic t_restart_ignored();
      int base, db;
      build_chain();
      base = ngot;
      db = ndone;
      launch(32'h0000_0100);
      repeat (6) @(negedge clk);
      start_addr = 32'h0080_0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (10) @(negedge clk);
      check(ndone - db == 1, "R10 single completion", ndone - db, 1);
      check_chain(base, "restart R10");
   endtask

   initial begin
      #700000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_chain();
      t_backpressure();
      t_term_start();
      t_mask();
      t_loop();
      t_restart_ignored();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule